// File: doc/BRIEF.md
# Configurable Countdown Timer with Sticky Interrupt

This block is a per-core timer driven by a single 64-bit configuration word. Software writes the word to set three things: an enable flag, a repeat/single-shot selector and a starting tick count. The count is carried inside the word itself. A write with the enable flag set starts a countdown at once. When the count runs out, the block raises a sticky interrupt request. In repeat mode it then reloads and keeps counting. In single-shot mode it clears the enable flag inside the stored word and stops.

Ticks come from an internal clock-enable divider. With `TICK_DIV` = 1 there is one tick on every clock. The block has three read values. The first is the stored configuration word. The second is the number of ticks left before the next expiry. The third is a 64-bit stamp counter that runs freely at the tick rate. An acknowledge pulse from the interrupt controller clears the request.

Top module: `cpu_cntdown_timer`

## Requirements
- R1: After reset, `cfg_rdata`, `remain_ticks`, `stamp_cnt` and `timer_irq` are all zero.
- R2: A cycle with `cfg_wr` high stores `cfg_wdata` unchanged, and the stored word appears on `cfg_rdata` on the next cycle. The same write loads `remain_ticks` with bits [47:2] of the word in place, not shifted. Bits [1:0] and [63:48] of `remain_ticks` read as zero.
- R3: A tick occurs once every `TICK_DIV` clocks. While bit 0 of the stored word (enable) is 1, each tick that does not expire lowers `remain_ticks` by exactly one.
- R4: An expiry is an enabled tick seen while `remain_ticks` is 1 or 0. A count of zero therefore expires on the first tick after it is written. On the cycle after an expiry, `timer_irq` is 1.
- R5: When bit 1 of the stored word is 1 (repeat mode), an expiry reloads `remain_ticks` from bits [47:2] of the stored word and the countdown continues.
- R6: When bit 1 is 0 (single-shot mode), an expiry clears bit 0 of the stored word, leaves every other bit unchanged, sets `remain_ticks` to zero and stops the countdown.
- R7: While bit 0 of the stored word is 0, `remain_ticks` holds its value and no expiry occurs.
- R8: `timer_irq` stays high until a cycle with `irq_ack` high clears it. If an acknowledge and an expiry fall on the same cycle, `timer_irq` stays 1.
- R9: If a configuration write falls on the cycle of an expiry, the written word and its count are loaded and the reload or enable clear is dropped. `timer_irq` is still raised.
- R10: `stamp_cnt` increases by one on every tick, whether the countdown is enabled or not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle |
| cfg_wdata | input | 64 | Configuration word: bit 0 enable, bit 1 repeat, bits [47:2] count |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| cfg_rdata | output | 64 | Stored configuration word |
| remain_ticks | output | 64 | Ticks left until the next expiry |
| stamp_cnt | output | 64 | Free-running tick counter |
| timer_irq | output | 1 | Sticky timer interrupt request |

## Verification
All four outputs come straight from registers. A wrong internal state therefore shows at the ports one cycle after the edge that produced it.

- A wrong divider phase skews `stamp_cnt` and `remain_ticks` within `TICK_DIV` clocks.
- A wrong compare for expiry makes `timer_irq` rise one tick too early or too late.
- In single-shot mode, an expiry that skips the enable clear shows up as a set bit 0 on `cfg_rdata` and a second interrupt one count later.

The bench compares every output against a behavioural model on every clock. This catches each of these faults on the first cycle it appears. The bench also drives a write exactly on a predicted expiry cycle and holds the acknowledge high through an expiry.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam int unsigned CDT_WORD_W = 64;

  typedef logic [CDT_WORD_W-1:0] cdt_word_t;

  // Field positions inside the configuration word
  localparam int unsigned CDT_EN_BIT  = 0;
  localparam int unsigned CDT_REP_BIT = 1;

  // What the countdown register does on the next edge
  typedef enum logic [2:0] {
    CD_HOLD   = 3'd0,
    CD_LOAD   = 3'd1,
    CD_RELOAD = 3'd2,
    CD_STOP   = 3'd3,
    CD_DEC    = 3'd4
  } cd_act_e;

endpackage

// File: rtl/cdt_tick_gen.sv
module cdt_tick_gen #(
  parameter int unsigned TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             last;

  assign last   = (div_q == LAST);
  assign tick_o = last;

  always_comb begin
    div_d = last ? '0 : div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && (TICK_DIV > 1)) |=> !tick_o); // R3

endmodule

// File: rtl/cdt_stamp_ctr.sv
module cdt_stamp_ctr #(
  parameter int unsigned STAMP_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  output logic [STAMP_W-1:0] stamp_o
);

  logic [STAMP_W-1:0] stamp_q, stamp_d;

  always_comb begin
    stamp_d = stamp_q + STAMP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stamp_q <= '0;
    else if (tick_i) stamp_q <= stamp_d;
  end

  assign stamp_o = stamp_q;

  AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (stamp_o == $past(stamp_o) + STAMP_W'(1))); // R10

  AST_STAMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(stamp_o)); // R10

endmodule

// File: rtl/cdt_countdown.sv
module cdt_countdown
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 48
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      wr_i,
  input  cdt_word_t wdata_i,
  output cdt_word_t cfg_o,
  output cdt_word_t rem_o,
  output logic      expire_o
);

  localparam int unsigned PAD_W = CDT_WORD_W - CNT_W;

  cdt_word_t        cfg_q, cfg_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [CNT_W-1:0] load_val, reload_val;
  logic             running, at_end;
  cd_act_e          act;

  assign running    = cfg_q[CDT_EN_BIT];
  assign at_end     = (rem_q[CNT_W-1:1] == '0);
  assign load_val   = {wdata_i[CNT_W-1:2], 2'b00};
  assign reload_val = {cfg_q[CNT_W-1:2], 2'b00};
  assign expire_o   = running & tick_i & at_end;

  // Action select: a write beats expiry, expiry beats plain decrement
  always_comb begin
    if (wr_i)                  act = CD_LOAD;
    else if (expire_o)         act = cfg_q[CDT_REP_BIT] ? CD_RELOAD : CD_STOP;
    else if (running & tick_i) act = CD_DEC;
    else                       act = CD_HOLD;
  end

  always_comb begin
    cfg_d = cfg_q;
    rem_d = rem_q;
    unique case (act)
      CD_LOAD: begin
        cfg_d = wdata_i;
        rem_d = load_val;
      end
      CD_RELOAD: rem_d = reload_val;
      CD_STOP: begin
        cfg_d[CDT_EN_BIT] = 1'b0;
        rem_d             = '0;
      end
      CD_DEC:  rem_d = rem_q - CNT_W'(1);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rem_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      rem_q <= rem_d;
    end
  end

  assign cfg_o = cfg_q;
  assign rem_o = {{PAD_W{1'b0}}, rem_q};

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[CDT_EN_BIT] && !wr_i) |=> $stable(rem_q)); // R7

  AST_NO_EXPIRE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[CDT_EN_BIT] |-> !expire_o); // R7

  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick_i && !at_end && !wr_i) |=> (rem_q == $past(rem_q) - CNT_W'(1))); // R3

  AST_ONESHOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !cfg_q[CDT_REP_BIT] && !wr_i) |=>
      (!cfg_q[CDT_EN_BIT] && (rem_q == '0) && (cfg_q[CDT_WORD_W-1:1] == $past(cfg_q[CDT_WORD_W-1:1])))); // R6

  AST_REPEAT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && cfg_q[CDT_REP_BIT] && !wr_i) |=>
      (cfg_q[CDT_EN_BIT] && (rem_q == {$past(cfg_q[CNT_W-1:2]), 2'b00}))); // R5

  AST_LOAD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (rem_q[1:0] == 2'b00)); // R2

endmodule

// File: rtl/cdt_irq_latch.sv
module cdt_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic ack_i,
  output logic irq_o
);

  logic irq_q, irq_d;

  always_comb begin
    irq_d = irq_q;
    if (ack_i)    irq_d = 1'b0;
    if (expire_i) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> irq_o); // R4

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> irq_o); // R8

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !expire_i) |=> !irq_o); // R8

endmodule

// File: rtl/cpu_cntdown_timer.sv
module cpu_cntdown_timer
  import cdt_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1,
  parameter int unsigned CNT_W    = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [63:0] cfg_wdata,
  input  logic        irq_ack,
  output logic [63:0] cfg_rdata,
  output logic [63:0] remain_ticks,
  output logic [63:0] stamp_cnt,
  output logic        timer_irq
);

  logic tick;
  logic expire;

  cdt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  cdt_stamp_ctr #(.STAMP_W(CDT_WORD_W)) u_stamp (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .stamp_o (stamp_cnt)
  );

  cdt_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .wr_i     (cfg_wr),
    .wdata_i  (cfg_wdata),
    .cfg_o    (cfg_rdata),
    .rem_o    (remain_ticks),
    .expire_o (expire)
  );

  cdt_irq_latch u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire_i (expire),
    .ack_i    (irq_ack),
    .irq_o    (timer_irq)
  );

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_rdata == $past(cfg_wdata))); // R2

  AST_WRITE_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && expire) |=> (timer_irq && (cfg_rdata == $past(cfg_wdata)))); // R9

endmodule

// File: tb/cpu_cntdown_timer_tb.sv
module cpu_cntdown_timer_tb_top;

  localparam int unsigned DIV   = 3;
  localparam logic [63:0] MASK  = 64'h0000_FFFF_FFFF_FFFC;
  localparam int unsigned LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic        irq_ack = 1'b0;
  logic [63:0] cfg_rdata, remain_ticks, stamp_cnt;
  logic        timer_irq;

  int    n_vec = 0;
  int    n_bad = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string scn = "R1";

  // behavioural reference state
  logic [63:0] m_cfg, m_rem, m_stamp;
  int          m_div;
  logic        m_irq;
  bit          tk, ex;

  always #2 clk = ~clk;

  cpu_cntdown_timer #(.TICK_DIV(DIV), .CNT_W(48)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .irq_ack      (irq_ack),
    .cfg_rdata    (cfg_rdata),
    .remain_ticks (remain_ticks),
    .stamp_cnt    (stamp_cnt),
    .timer_irq    (timer_irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = '0; m_rem = '0; m_stamp = '0; m_div = 0; m_irq = 1'b0;
    end else begin
      tk = (m_div == DIV - 1);
      ex = m_cfg[0] && tk && (m_rem <= 64'd1);
      m_div = tk ? 0 : m_div + 1;
      if (tk) m_stamp = m_stamp + 64'd1;
      if (cfg_wr) begin
        m_cfg = cfg_wdata;
        m_rem = cfg_wdata & MASK;
      end else if (ex) begin
        if (m_cfg[1]) m_rem = m_cfg & MASK;
        else begin m_rem = '0; m_cfg[0] = 1'b0; end
      end else if (m_cfg[0] && tk) begin
        m_rem = m_rem - 64'd1;
      end
      if (ex) m_irq = 1'b1;
      else if (irq_ack) m_irq = 1'b0;
    end
  end

  function automatic bit expiry_pending();
    return m_cfg[0] && (m_div == DIV - 1) && (m_rem <= 64'd1);
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk({"R2/", scn}, "cfg_rdata", cfg_rdata, m_cfg);
      chk({"R3/", scn}, "remain_ticks", remain_ticks, m_rem);
      chk({"R4/", scn}, "timer_irq", {63'd0, timer_irq}, {63'd0, m_irq});
      chk({"R10/", scn}, "stamp_cnt", stamp_cnt, m_stamp);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [63:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    wait (cycles > LIMIT);
    n_bad++;
    $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, LIMIT);
    finish_run();
  end

  initial begin
    logic [63:0] s0;
    logic [63:0] v;
    run(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "cfg_rdata", cfg_rdata, 64'd0);
    chk("R1", "remain_ticks", remain_ticks, 64'd0);
    chk("R1", "stamp_cnt", stamp_cnt, 64'd1 & {63'd0, 1'b0});
    chk("R1", "timer_irq", {63'd0, timer_irq}, 64'd0);

    // R2: masking of the loaded count
    scn = "R2";
    v = 64'hABCD_0012_3456_789B;
    wr_cfg(v);
    chk("R2", "cfg_rdata", cfg_rdata, v);
    chk("R2", "remain_ticks", remain_ticks, v & MASK);

    // R3 and R10: decrement per tick across 30 clocks (10 ticks)
    scn = "R3";
    wr_cfg(64'h403);
    s0 = stamp_cnt;
    run(30);
    chk("R3", "remain_ticks", remain_ticks, 64'h400 - 64'd10);
    chk("R10", "stamp delta", stamp_cnt - s0, 64'd10);

    // R5: repeat mode with count 8
    scn = "R5";
    wr_cfg(64'hB);
    run(40);
    chk("R5", "cfg enable kept", {63'd0, cfg_rdata[0]}, 64'd1);
    chk("R5", "timer_irq", {63'd0, timer_irq}, 64'd1);
    ack();
    run(60);

    // R6: single-shot with high bits set, count 12
    scn = "R6";
    v = 64'h5A00_0000_0000_000D;
    wr_cfg(v);
    ack();
    run(60);
    chk("R6", "cfg_rdata", cfg_rdata, v & ~64'd1);
    chk("R6", "remain_ticks", remain_ticks, 64'd0);
    chk("R6", "timer_irq", {63'd0, timer_irq}, 64'd1);
    ack();
    run(30);
    chk("R6", "no second irq", {63'd0, timer_irq}, 64'd0);

    // R7: disabled write freezes count, no expiry
    scn = "R7";
    wr_cfg(64'h100);
    run(40);
    chk("R7", "remain_ticks", remain_ticks, 64'h100);
    chk("R7", "timer_irq", {63'd0, timer_irq}, 64'd0);

    // R4: zero count expires on first tick
    scn = "R4";
    wr_cfg(64'h1);
    run(DIV);
    chk("R4", "timer_irq", {63'd0, timer_irq}, 64'd1);
    chk("R4", "cfg_rdata", cfg_rdata, 64'd0);

    // R8: sticky, then ack held through repeat expiries
    scn = "R8";
    run(20);
    chk("R8", "irq held", {63'd0, timer_irq}, 64'd1);
    wr_cfg(64'h7);
    @(negedge clk);
    irq_ack = 1'b1;
    for (int i = 0; i < 200 && !expiry_pending(); i++) @(negedge clk);
    @(negedge clk);
    chk("R8", "expiry beats ack", {63'd0, timer_irq}, 64'd1);
    @(negedge clk);
    irq_ack = 1'b0;
    @(negedge clk);
    chk("R8", "ack clears", {63'd0, timer_irq}, 64'd0);

    // R9: write on the exact expiry cycle
    scn = "R9";
    wr_cfg(64'hB);
    ack();
    for (int i = 0; i < 200 && !expiry_pending(); i++) @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 64'h41;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R9", "cfg_rdata", cfg_rdata, 64'h41);
    chk("R9", "remain_ticks", remain_ticks, 64'h40);
    chk("R9", "timer_irq", {63'd0, timer_irq}, 64'd1);
    run(250);

    // R10: stamp keeps running while stopped
    scn = "R10";
    wr_cfg(64'h0);
    s0 = stamp_cnt;
    run(33);
    chk("R10", "stamp delta", stamp_cnt - s0, 64'd11);

    finish_run();
  end

endmodule